// File: doc/BRIEF.md
# Batch-Loading Delay Queue

This block is a synchronous first-in first-out store that takes in a batch of zero or more words on every clock edge and gives out at most one word per cycle. The producer drives a packed array of `P` lanes together with a count saying how many of the lowest lanes carry data. The consumer sees the word at the head of the stored queue, with a flag that says whether a word is present. The consumer never stalls the block: while the queue holds anything, one word leaves on every edge.

An empty queue is handled differently from a queue that holds words. If the queue is empty, the arriving batch becomes the whole queue and nothing leaves that cycle. If the queue holds words, the batch is appended behind them and then the head word is removed. Capacity is fixed at `N` words. Batch words that do not fit are discarded, and the block reports this with a one-cycle overflow pulse. Since the output comes from stored state, a word is visible one cycle after the edge that accepted it at the earliest.

Top module: `mpsp_fifo`

## Requirements
- R1: A synchronous active-high reset empties the queue. After the reset edge `empty` is 1 and `out_valid` and `overflow` are 0.
- R2: The outputs depend only on the stored queue. A batch driven during a cycle does not change `out_valid` or `out_data` before the next rising edge.
- R3: At an edge where the queue is empty, the valid words of the batch become the entire queue and no word is removed.
- R4: At an edge where the queue holds words, the accepted batch words are placed behind the stored words and then the head word is removed. The queue therefore shrinks by exactly one on an edge with a zero count.
- R5: Within a batch, lane 0 enters first, then lane 1, and so on. `out_data` always shows the oldest stored word.
- R6: `out_valid` is 0 and `empty` is 1 exactly when the queue holds no words.
- R7: `full` is 1 exactly when the queue holds `N` words.
- R8: The room check uses the fill level before the removal. Batch words beyond the free room are discarded from the highest lane downward. `overflow` is 1 for one cycle, in the cycle after the edge that discarded at least one word, and is 0 otherwise.
- R9: Lanes at or above `in_cnt` are ignored, and a count of zero adds nothing. A count above `P` is treated as `P`.
- R10: Parameters require `W >= 1`, `P >= 1`, `N >= 2` and `N >= P`. Other values stop elaboration.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst | input | 1 | Synchronous reset, active high |
| in_data | input | P*W | Batch lanes, lane 0 in the lowest bits |
| in_cnt | input | $clog2(P+1) | Number of valid lanes, counted from lane 0 |
| out_data | output | W | Word at the head of the queue |
| out_valid | output | 1 | A word is present on `out_data` |
| empty | output | 1 | Queue holds no words |
| full | output | 1 | Queue holds N words |
| overflow | output | 1 | One-cycle pulse after batch words were discarded |

## Verification
A wrong fill level shows up in the cycle after the edge that corrupted it. It appears as a wrong `empty` or `full` flag, a missing or spurious `overflow` pulse, or `out_valid` dropping while the reference queue still holds words. A wrong read or write pointer can leave the flags correct while `out_data` is wrong, either at once or only when the corrupted slot reaches the head. For that reason every cycle compares the head word against the reference queue. The pointers wrap at a capacity that is not a power of two, and long runs with mixed batch sizes cover that wrap many times.

// File: rtl/mpsp_fifo_pkg.sv
package mpsp_fifo_pkg;

   // width of a slot index for a store of n entries
   function automatic int unsigned slot_bits(int unsigned n);
      return (n < 2) ? 1 : $clog2(n);
   endfunction

   // width of a counter able to hold the value n
   function automatic int unsigned count_bits(int unsigned n);
      return (n < 1) ? 1 : $clog2(n + 1);
   endfunction

endpackage

// File: rtl/mpsp_fifo_wrap.sv
module mpsp_fifo_wrap
   import mpsp_fifo_pkg::*;
#(
   parameter int unsigned N  = 6,
   parameter int unsigned AW = slot_bits(N),
   localparam int unsigned SW = AW + 1
) (
   input  logic [AW-1:0] base,
   input  logic [SW-1:0] inc,
   output logic [AW-1:0] slot
);

   logic [SW-1:0] sum;
   assign sum = SW'(base) + inc;

   generate
      if ((N & (N - 1)) == 0) begin : g_pow2
         // natural wrap of the index bits
         assign slot = sum[AW-1:0];
      end else begin : g_cmp
         // base < N and inc <= N, so one subtraction is enough
         logic [SW-1:0] folded;
         assign folded = (sum >= SW'(N)) ? (sum - SW'(N)) : sum;
         assign slot   = folded[AW-1:0];
      end
   endgenerate

endmodule

// File: rtl/mpsp_fifo_ctrl.sv
module mpsp_fifo_ctrl
   import mpsp_fifo_pkg::*;
#(
   parameter int unsigned P  = 6,
   parameter int unsigned N  = 6,
   parameter int unsigned AW = slot_bits(N),
   parameter int unsigned CW = count_bits(N),
   parameter int unsigned NW = count_bits(P),
   localparam int unsigned SW = AW + 1
) (
   input  logic          clk,
   input  logic          rst,
   input  logic [NW-1:0] in_cnt,
   output logic [CW-1:0] level,
   output logic [CW-1:0] take,
   output logic [AW-1:0] rd_ptr,
   output logic [AW-1:0] wr_ptr,
   output logic          ovf_q
);

   logic [NW-1:0] req;
   logic [CW-1:0] room;
   logic          pop;
   logic          dropped;
   logic [AW-1:0] rd_nxt;
   logic [AW-1:0] wr_nxt;

   always_comb begin
      req     = (in_cnt > NW'(P)) ? NW'(P) : in_cnt;
      room    = CW'(N) - level;
      dropped = CW'(req) > room;
      take    = dropped ? room : CW'(req);
      pop     = (level != '0);
   end

   mpsp_fifo_wrap #(.N(N), .AW(AW)) u_wr_adv (
      .base (wr_ptr),
      .inc  (SW'(take)),
      .slot (wr_nxt)
   );

   mpsp_fifo_wrap #(.N(N), .AW(AW)) u_rd_adv (
      .base (rd_ptr),
      .inc  (SW'(pop)),
      .slot (rd_nxt)
   );

   always_ff @(posedge clk) begin
      if (rst) begin
         level  <= '0;
         rd_ptr <= '0;
         wr_ptr <= '0;
         ovf_q  <= 1'b0;
      end else begin
         level  <= level + take - CW'(pop);
         rd_ptr <= rd_nxt;
         wr_ptr <= wr_nxt;
         ovf_q  <= dropped;
      end
   end

endmodule

// File: rtl/mpsp_fifo_store.sv
module mpsp_fifo_store
   import mpsp_fifo_pkg::*;
#(
   parameter int unsigned W  = 8,
   parameter int unsigned P  = 6,
   parameter int unsigned N  = 6,
   parameter int unsigned AW = slot_bits(N),
   parameter int unsigned CW = count_bits(N),
   localparam int unsigned SW = AW + 1
) (
   input  logic                clk,
   input  logic [P-1:0][W-1:0] in_data,
   input  logic [CW-1:0]       take,
   input  logic [AW-1:0]       wr_ptr,
   input  logic [AW-1:0]       rd_ptr,
   output logic [W-1:0]        head
);

   logic [W-1:0]  mem [N];
   logic [AW-1:0] lane_slot [P];
   logic [P-1:0]  lane_en;

   generate
      for (genvar i = 0; i < P; i++) begin : g_lane
         mpsp_fifo_wrap #(.N(N), .AW(AW)) u_slot (
            .base (wr_ptr),
            .inc  (SW'(i)),
            .slot (lane_slot[i])
         );
         assign lane_en[i] = (CW'(i) < take);
      end
   endgenerate

   always_ff @(posedge clk) begin
      for (int e = 0; e < N; e++) begin
         for (int i = 0; i < P; i++) begin
            if (lane_en[i] && (lane_slot[i] == AW'(e))) begin
               mem[e] <= in_data[i];
            end
         end
      end
   end

   assign head = mem[rd_ptr];

endmodule

// File: rtl/mpsp_fifo.sv
module mpsp_fifo
   import mpsp_fifo_pkg::*;
#(
   parameter int unsigned W = 8,
   parameter int unsigned P = 6,
   parameter int unsigned N = 6,
   localparam int unsigned AW = slot_bits(N),
   localparam int unsigned CW = count_bits(N),
   localparam int unsigned NW = count_bits(P)
) (
   input  logic                clk,
   input  logic                rst,
   input  logic [P-1:0][W-1:0] in_data,
   input  logic [NW-1:0]       in_cnt,
   output logic [W-1:0]        out_data,
   output logic                out_valid,
   output logic                empty,
   output logic                full,
   output logic                overflow
);

   // R10: parameter legality
   generate
      if (W < 1) begin : g_bad_w
         $error("mpsp_fifo: W must be at least 1");
      end
      if (P < 1) begin : g_bad_p
         $error("mpsp_fifo: P must be at least 1");
      end
      if (N < 2) begin : g_bad_n
         $error("mpsp_fifo: N must be at least 2");
      end
      if (N < P) begin : g_bad_np
         $error("mpsp_fifo: N must not be below P");
      end
   endgenerate

   logic [CW-1:0] level;
   logic [CW-1:0] take;
   logic [AW-1:0] rd_ptr;
   logic [AW-1:0] wr_ptr;
   logic          ovf_q;

   mpsp_fifo_ctrl #(.P(P), .N(N), .AW(AW), .CW(CW), .NW(NW)) u_ctrl (
      .clk    (clk),
      .rst    (rst),
      .in_cnt (in_cnt),
      .level  (level),
      .take   (take),
      .rd_ptr (rd_ptr),
      .wr_ptr (wr_ptr),
      .ovf_q  (ovf_q)
   );

   mpsp_fifo_store #(.W(W), .P(P), .N(N), .AW(AW), .CW(CW)) u_store (
      .clk     (clk),
      .in_data (in_data),
      .take    (take),
      .wr_ptr  (wr_ptr),
      .rd_ptr  (rd_ptr),
      .head    (out_data)
   );

   assign out_valid = (level != '0);
   assign empty     = (level == '0);
   assign full      = (level == CW'(N));
   assign overflow  = ovf_q;

endmodule

// File: rtl/mpsp_fifo_chk.sv
module mpsp_fifo_chk #(
   parameter int unsigned P  = 6,
   parameter int unsigned N  = 6,
   parameter int unsigned CW = 3,
   parameter int unsigned NW = 3
) (
   input logic          clk,
   input logic          rst,
   input logic [NW-1:0] in_cnt,
   input logic [CW-1:0] level,
   input logic          out_valid,
   input logic          empty,
   input logic          full,
   input logic          overflow
);

   // R1
   reset_state_chk: assert property (@(posedge clk)
      rst |=> (empty && !out_valid && !overflow));

   // R3
   empty_load_chk: assert property (@(posedge clk) disable iff (rst)
      (empty && in_cnt != '0 && in_cnt <= NW'(P)) |=> (level == CW'($past(in_cnt))));

   // R4
   single_pop_chk: assert property (@(posedge clk) disable iff (rst)
      (!empty && in_cnt == '0) |=> (level == $past(level) - CW'(1)));

   // R9
   idle_empty_chk: assert property (@(posedge clk) disable iff (rst)
      (empty && in_cnt == '0) |=> (empty && !out_valid));

   // R8
   no_overflow_chk: assert property (@(posedge clk) disable iff (rst)
      empty |=> !overflow);

   // R8
   full_drop_chk: assert property (@(posedge clk) disable iff (rst)
      (full && in_cnt != '0) |=> overflow);

endmodule

bind mpsp_fifo mpsp_fifo_chk #(.P(P), .N(N), .CW(CW), .NW(NW)) u_chk (
   .clk       (clk),
   .rst       (rst),
   .in_cnt    (in_cnt),
   .level     (level),
   .out_valid (out_valid),
   .empty     (empty),
   .full      (full),
   .overflow  (overflow)
);

// File: tb/mpsp_fifo_tb.sv
module mpsp_fifo_tb;

   localparam int CLK_PERIOD = 10;
   localparam int W  = 8;
   localparam int P  = 6;
   localparam int N  = 6;
   localparam int NW = $clog2(P + 1);

   logic                clk = 1'b0;
   logic                rst = 1'b1;
   logic [P-1:0][W-1:0] in_data = '0;
   logic [NW-1:0]       in_cnt = '0;
   logic [W-1:0]        out_data;
   logic                out_valid;
   logic                empty;
   logic                full;
   logic                overflow;

   int  checks = 0;
   int  errors = 0;
   bit  done   = 1'b0;
   logic [W-1:0] sb [$];
   bit  exp_ovf = 1'b0;

   always #(CLK_PERIOD / 2) clk = ~clk;

   mpsp_fifo #(.W(W), .P(P), .N(N)) u_dut (
      .clk       (clk),
      .rst       (rst),
      .in_data   (in_data),
      .in_cnt    (in_cnt),
      .out_data  (out_data),
      .out_valid (out_valid),
      .empty     (empty),
      .full      (full),
      .overflow  (overflow)
   );

   task automatic check(input bit ok, input string req, input string what,
                        input int act, input int exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
      end
   endtask

   function automatic logic [P-1:0][W-1:0] batch(input int base);
      logic [P-1:0][W-1:0] b;
      for (int i = 0; i < P; i++) b[i] = W'(base + i);
      return b;
   endfunction

   // monitor: compare ports against the scoreboard head
   task automatic compare(input string req);
      bit ev;
      ev = (sb.size() != 0);
      check(out_valid == ev, "R6", {req, " out_valid"}, int'(out_valid), int'(ev));
      check(empty == !ev, "R6", {req, " empty"}, int'(empty), int'(!ev));
      check(full == (sb.size() == N), "R7", {req, " full"}, int'(full), int'(sb.size() == N));
      check(overflow == exp_ovf, "R8", {req, " overflow"}, int'(overflow), int'(exp_ovf));
      if (ev && out_valid)
         check(out_data == sb[0], req, "head word", int'(out_data), int'(sb[0]));
   endtask

   // driver: apply a batch, update the reference queue at the edge
   task automatic step(input int cnt, input logic [P-1:0][W-1:0] d, input string req);
      int take;
      in_cnt  = NW'(cnt);
      in_data = d;
      @(posedge clk);
      take    = (cnt > P) ? P : cnt;
      exp_ovf = 1'b0;
      if (sb.size() == 0) begin
         for (int i = 0; i < take; i++) sb.push_back(d[i]);
      end else begin
         for (int i = 0; i < take; i++) begin
            if (sb.size() < N) sb.push_back(d[i]);
            else exp_ovf = 1'b1;
         end
         void'(sb.pop_front());
      end
      @(negedge clk);
      compare(req);
   endtask

   initial begin
      repeat (100000) @(posedge clk);
      if (!done) begin
         errors++;
         $display("FAIL watchdog: actual=running expected=finished");
         $display("Result: errors=%0d of %0d checks", errors, checks + 1);
         $finish;
      end
   end

   initial begin
      // R1: reset state
      in_data = batch(8'h90);
      in_cnt  = NW'(3);
      repeat (3) @(posedge clk);
      @(negedge clk);
      exp_ovf = 1'b0;
      compare("R1");
      check(empty == 1'b1, "R1", "empty after reset", int'(empty), 1);
      rst    = 1'b0;
      in_cnt = '0;

      // R2: batch driven on an empty queue is not visible before the edge
      in_cnt  = NW'(6);
      in_data = batch(8'h10);
      #1;
      check(out_valid == 1'b0, "R2", "valid before edge", int'(out_valid), 0);
      step(6, batch(8'h10), "R3");           // fills to N, no pop
      check(out_data == 8'h10, "R5", "lane 0 first", int'(out_data), 8'h10);

      step(2, batch(8'h20), "R8");           // full: both dropped, pop
      step(0, batch(8'hee), "R9");           // nothing added, pulse ends
      step(3, batch(8'h30), "R8");           // room 2, lane 2 dropped
      step(1, batch(8'h40), "R4");           // fits exactly
      for (int k = 0; k < 5; k++) step(0, batch(8'hc0 + k), "R4");
      step(0, batch(8'h55), "R9");           // empty stays empty
      step(7, batch(8'h60), "R9");           // count above P loads P words
      for (int k = 0; k < 6; k++) step(0, '0, "R5");

      // mixed batch sizes, many pointer wraps
      for (int k = 0; k < 300; k++)
         step((k * 5 + k / 7) % 8, batch((k * 13) & 8'hff), "R4");

      // R1: reset while holding words
      step(4, batch(8'h70), "R4");
      rst     = 1'b1;
      in_cnt  = NW'(5);
      @(posedge clk);
      sb.delete();
      exp_ovf = 1'b0;
      @(negedge clk);
      compare("R1");
      rst    = 1'b0;
      in_cnt = '0;
      step(0, '0, "R9");

      done = 1'b1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end

endmodule